// File: doc/BRIEF.md
# Partitioned Non-Volatile RAM Access Router

This block sits between an 8051-style core and two memory buses. For every access it decides whether the target is the byte-wide non-volatile RAM, reached through two active-low chip enables, or the standard expanded bus. The decision depends on four things: the 16-bit logical address, whether the access is a program fetch or a data access, and two settings held in a memory-control register. The first setting is a movable program/data boundary inside the first RAM. The second is the size of the RAM that is fitted.

The memory-control register sits at special-function-register address C6h and is written through a simple write port. It holds a 4-bit boundary code, a RAM-size bit and a redirect bit. The redirect bit sends every data access below the RAM size to the second RAM. The RAM-size bit can only be changed while the core runs its loader. The boundary and redirect bits can be changed at any time. The routing itself is combinational, so a new address is decoded in the same cycle. A register write takes effect from the clock edge that captures it.

Top module: `nvdec_top`

## Requirements
- R1: After reset the boundary code is 15 (32 kB), the RAM-size bit is 1 (32 kB) and the redirect bit is 0. With these values a program fetch at 7FFFh selects the first RAM and a data access at 0000h goes to the expanded bus.
- R2: A write with `sfr_we` high and `sfr_addr` equal to C6h loads the register at the next rising edge. Bits 7:4 are the boundary code, bit 3 is the RAM-size bit and bit 2 is the redirect bit. A write to any other address leaves the decode unchanged.
- R3: The RAM-size bit is loaded only when `boot_mode` is 1. A write made with `boot_mode` at 0 keeps the old RAM-size bit and still loads the other two fields.
- R4: The boundary address is the code times 2048 for codes 0 to 14, and 32768 for code 15. The RAM size is 8192 when the size bit is 0 and 32768 when it is 1.
- R5: A program fetch (`acc_prog` = 1) below the boundary drives `ce1_n` low. Any other program fetch goes to the expanded bus.
- R6: With the redirect bit at 0, a data access at or above the boundary and below the RAM size drives `ce1_n` low.
- R7: With the redirect bit at 1, a data access below the RAM size drives `ce2_n` low and keeps `ce1_n` high.
- R8: The redirect bit never changes how a program fetch is decoded, and a program fetch never selects the second RAM.
- R9: An access that selects neither RAM sets `exp_sel` to 1 with both chip enables high. Exactly one of `ce1_n` low, `ce2_n` low or `exp_sel` high is true at all times.
- R10: `ram_addr` equals bits 14:0 of `acc_addr`.
- R11: `ram_we_n` is low only when `acc_wr` is 1 and one chip enable is low.
- R12: A boundary above the RAM size is kept as written. Program fetches below it still select the first RAM, and no data access selects the first RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| boot_mode | input | 1 | High while the core runs its loader |
| acc_addr | input | 16 | Logical address of the current access |
| acc_prog | input | 1 | 1 for a program fetch, 0 for a data access |
| acc_wr | input | 1 | Core write strobe, active high |
| ram_addr | output | 15 | Address to the byte-wide RAM |
| ce1_n | output | 1 | First RAM enable, active low |
| ce2_n | output | 1 | Second RAM enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| exp_sel | output | 1 | High when the access goes to the expanded bus |

## Verification
The only internal state is the three register fields, so any corruption shows up as a wrong routing decision. A bad boundary code moves the first RAM's split point. A lost or leaked size bit moves the data ceiling from 8 kB to 32 kB or back. A stuck redirect bit swaps the first and second chip enables. Because the decode is combinational, the fault appears in the cycle of the very next access that touches the shifted edge. The bench therefore probes the addresses on each side of every boundary and every RAM-size edge, for both access types.

// File: rtl/nvdec_pkg.sv
package nvdec_pkg;

    localparam int CODE_W = 4;

    // Memory-control register contents
    typedef struct packed {
        logic [CODE_W-1:0] part_code;
        logic              range_big;
        logic              redirect;
    } nvdec_ctl_t;

    // Routing target of one access
    typedef enum logic [1:0] {
        TGT_EXP = 2'd0,
        TGT_CE1 = 2'd1,
        TGT_CE2 = 2'd2
    } nvdec_tgt_e;

    localparam nvdec_ctl_t CTL_RESET = '{part_code: '1, range_big: 1'b1, redirect: 1'b0};

endpackage

// File: rtl/nvdec_ctl_reg.sv
module nvdec_ctl_reg
    import nvdec_pkg::*;
#(
    parameter int         SFR_AW   = 8,
    parameter logic [7:0] CTL_ADDR = 8'hC6,
    parameter int         CODE_LSB = 4,
    parameter int         SIZE_BIT = 3,
    parameter int         REDIR_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              boot_mode,
    output nvdec_ctl_t        ctl_q
);

    logic       hit;
    nvdec_ctl_t ctl_d;

    assign hit = sfr_we && (sfr_addr == SFR_AW'(CTL_ADDR));

    always_comb begin
        ctl_d = ctl_q;
        if (hit) begin
            ctl_d.part_code = sfr_wdata[CODE_LSB +: CODE_W];
            ctl_d.redirect  = sfr_wdata[REDIR_BIT];
            if (boot_mode) begin
                ctl_d.range_big = sfr_wdata[SIZE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/nvdec_bound.sv
module nvdec_bound
    import nvdec_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int STEP_LOG2  = 11,
    parameter int SMALL_LOG2 = 13,
    parameter int LARGE_LOG2 = 15
) (
    input  nvdec_ctl_t        ctl_q,
    output logic [ADDR_W-1:0] part_bytes,
    output logic [ADDR_W-1:0] range_bytes
);

    localparam int          TOP_CODE = (1 << CODE_W) - 1;
    localparam logic [ADDR_W-1:0] SMALL_SIZE = ADDR_W'(1) << SMALL_LOG2;
    localparam logic [ADDR_W-1:0] LARGE_SIZE = ADDR_W'(1) << LARGE_LOG2;

    generate
        if (STEP_LOG2 * 1 < ADDR_W) begin : g_scaled
            always_comb begin
                if (ctl_q.part_code == CODE_W'(TOP_CODE)) begin
                    part_bytes = LARGE_SIZE;
                end else begin
                    part_bytes = ADDR_W'(ctl_q.part_code) << STEP_LOG2;
                end
            end
        end else begin : g_flat
            assign part_bytes = LARGE_SIZE;
        end
    endgenerate

    assign range_bytes = ctl_q.range_big ? LARGE_SIZE : SMALL_SIZE;

endmodule

// File: rtl/nvdec_route.sv
module nvdec_route
    import nvdec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_prog,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] part_bytes,
    input  logic [ADDR_W-1:0] range_bytes,
    output nvdec_tgt_e        tgt
);

    logic below_part;
    logic below_range;

    assign below_part  = acc_addr < part_bytes;
    assign below_range = acc_addr < range_bytes;

    always_comb begin
        tgt = TGT_EXP;
        if (acc_prog) begin
            if (below_part) tgt = TGT_CE1;
        end else if (redirect) begin
            if (below_range) tgt = TGT_CE2;
        end else if (!below_part && below_range) begin
            tgt = TGT_CE1;
        end
    end

endmodule

// File: rtl/nvdec_top.sv
module nvdec_top
    import nvdec_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter int         RAM_AW     = 15,
    parameter int         SFR_AW     = 8,
    parameter logic [7:0] CTL_ADDR   = 8'hC6,
    parameter int         STEP_LOG2  = 11,
    parameter int         SMALL_LOG2 = 13,
    parameter int         LARGE_LOG2 = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              boot_mode,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_prog,
    input  logic              acc_wr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ce1_n,
    output logic              ce2_n,
    output logic              ram_we_n,
    output logic              exp_sel
);

    nvdec_ctl_t        ctl_q;
    logic [ADDR_W-1:0] part_bytes;
    logic [ADDR_W-1:0] range_bytes;
    nvdec_tgt_e        tgt;

    nvdec_ctl_reg #(
        .SFR_AW   (SFR_AW),
        .CTL_ADDR (CTL_ADDR),
        .CODE_LSB (4),
        .SIZE_BIT (3),
        .REDIR_BIT(2)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sfr_we   (sfr_we),
        .sfr_addr (sfr_addr),
        .sfr_wdata(sfr_wdata),
        .boot_mode(boot_mode),
        .ctl_q    (ctl_q)
    );

    nvdec_bound #(
        .ADDR_W    (ADDR_W),
        .STEP_LOG2 (STEP_LOG2),
        .SMALL_LOG2(SMALL_LOG2),
        .LARGE_LOG2(LARGE_LOG2)
    ) u_bound (
        .ctl_q      (ctl_q),
        .part_bytes (part_bytes),
        .range_bytes(range_bytes)
    );

    nvdec_route #(
        .ADDR_W(ADDR_W)
    ) u_route (
        .acc_addr   (acc_addr),
        .acc_prog   (acc_prog),
        .redirect   (ctl_q.redirect),
        .part_bytes (part_bytes),
        .range_bytes(range_bytes),
        .tgt        (tgt)
    );

    always_comb begin
        ce1_n   = 1'b1;
        ce2_n   = 1'b1;
        exp_sel = 1'b0;
        unique case (tgt)
            TGT_CE1: ce1_n   = 1'b0;
            TGT_CE2: ce2_n   = 1'b0;
            default: exp_sel = 1'b1;
        endcase
    end

    assign ram_addr = acc_addr[RAM_AW-1:0];
    assign ram_we_n = !(acc_wr && (tgt != TGT_EXP));

endmodule

// File: rtl/nvdec_chk.sv
module nvdec_chk
    import nvdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SFR_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sfr_we,
    input logic [SFR_AW-1:0] sfr_addr,
    input logic              boot_mode,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_prog,
    input logic              acc_wr,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic              ram_we_n,
    input logic              exp_sel,
    input nvdec_ctl_t        ctl_q,
    input logic [ADDR_W-1:0] part_bytes,
    input logic [ADDR_W-1:0] range_bytes
);

    // R9: exactly one destination
    a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!ce1_n, !ce2_n, exp_sel}) == 1);

    // R8: program fetches never reach the second RAM
    a_r8_prog_no_ce2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_prog |-> ce2_n);

    // R5: fetch below the boundary selects the first RAM
    a_r5_prog_ce1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_prog && (acc_addr < part_bytes)) |-> !ce1_n);

    // R6: data window between boundary and RAM size
    a_r6_data_ce1: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_prog && !ctl_q.redirect && (acc_addr >= part_bytes) && (acc_addr < range_bytes)) |-> !ce1_n);

    // R7: redirected data goes to the second RAM
    a_r7_redirect_ce2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_prog && ctl_q.redirect && (acc_addr < range_bytes)) |-> (!ce2_n && ce1_n));

    // R11: write strobe only with a write and a chip enable
    a_r11_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (acc_wr && (!ce1_n || !ce2_n)));

    // R3: RAM-size bit holds outside the loader
    a_r3_size_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_mode |=> $stable(ctl_q.range_big));

    // R2: register holds without a write to its address
    a_r2_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_we && (sfr_addr == SFR_AW'(8'hC6))) |=> $stable(ctl_q));

endmodule

bind nvdec_top nvdec_chk #(
    .ADDR_W(ADDR_W),
    .SFR_AW(SFR_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfr_we     (sfr_we),
    .sfr_addr   (sfr_addr),
    .boot_mode  (boot_mode),
    .acc_addr   (acc_addr),
    .acc_prog   (acc_prog),
    .acc_wr     (acc_wr),
    .ce1_n      (ce1_n),
    .ce2_n      (ce2_n),
    .ram_we_n   (ram_we_n),
    .exp_sel    (exp_sel),
    .ctl_q      (ctl_q),
    .part_bytes (part_bytes),
    .range_bytes(range_bytes)
);

// File: tb/nvdec_top_tb.sv
module nvdec_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        logic        ce1_n;
        logic        ce2_n;
        logic        exp_sel;
        logic        we_n;
        logic [14:0] addr;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic        boot_mode = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        acc_prog = 1'b0;
    logic        acc_wr = 1'b0;
    logic [14:0] ram_addr;
    logic        ce1_n, ce2_n, ram_we_n, exp_sel;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model of the register, kept from the requirements
    int m_code  = 15;
    bit m_big   = 1'b1;
    bit m_redir = 1'b0;

    exp_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvdec_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sfr_we   (sfr_we),
        .sfr_addr (sfr_addr),
        .sfr_wdata(sfr_wdata),
        .boot_mode(boot_mode),
        .acc_addr (acc_addr),
        .acc_prog (acc_prog),
        .acc_wr   (acc_wr),
        .ram_addr (ram_addr),
        .ce1_n    (ce1_n),
        .ce2_n    (ce2_n),
        .ram_we_n (ram_we_n),
        .exp_sel  (exp_sel)
    );

    function automatic int part_of(int code);
        return (code == 15) ? 32768 : code * 2048;   // R4
    endfunction

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d, input bit boot);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d; boot_mode = boot;
        @(negedge clk);
        sfr_we = 1'b0; boot_mode = 1'b0;
        if (a == 8'hC6) begin
            m_code  = int'(d[7:4]);
            m_redir = d[2];
            if (boot) m_big = d[3];
        end
    endtask

    // driver: applies one access and pushes what the requirements predict
    task automatic drive(input logic [15:0] a, input bit prog, input bit wr, input string force_tag);
        exp_item_t it;
        int p, r, ai;
        int tgt;   // 0 expanded, 1 first RAM, 2 second RAM
        p  = part_of(m_code);
        r  = m_big ? 32768 : 8192;
        ai = int'(a);
        if (prog) begin
            tgt = (ai < p) ? 1 : 0;
            it.tag = m_redir ? "R8" : "R5";
        end else if (m_redir) begin
            tgt = (ai < r) ? 2 : 0;
            it.tag = "R7";
        end else begin
            tgt = (ai >= p && ai < r) ? 1 : 0;
            it.tag = "R6";
        end
        if (tgt == 0) it.tag = "R9";
        if (p > r) it.tag = "R12";
        if (prog && (ai == p || ai == p - 1)) it.tag = "R4";
        if (force_tag != "") it.tag = force_tag;
        it.ce1_n   = (tgt != 1);
        it.ce2_n   = (tgt != 2);
        it.exp_sel = (tgt == 0);
        it.we_n    = !(wr && tgt != 0);
        it.addr    = a[14:0];
        @(negedge clk);
        acc_addr = a; acc_prog = prog; acc_wr = wr;
        exp_q.push_back(it);
        @(posedge clk);
        #(CLK_PERIOD*3/8);
    endtask

    // monitor: pops and compares a quarter period after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_item_t e;
                e = exp_q.pop_front();
                n_vec++;
                if ({ce1_n, ce2_n, exp_sel} !== {e.ce1_n, e.ce2_n, e.exp_sel}) begin
                    n_bad++;
                    $display("FAIL %s addr=%h prog=%0b: ce1_n,ce2_n,exp_sel=%b%b%b expected %b%b%b",
                             e.tag, acc_addr, acc_prog, ce1_n, ce2_n, exp_sel, e.ce1_n, e.ce2_n, e.exp_sel);
                end else if (ram_addr !== e.addr) begin
                    n_bad++;
                    $display("FAIL R10 ram_addr=%h expected %h", ram_addr, e.addr);
                end else if (ram_we_n !== e.we_n) begin
                    n_bad++;
                    $display("FAIL R11 ram_we_n=%b expected %b", ram_we_n, e.we_n);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: done=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        drive(16'h7FFF, 1'b1, 1'b0, "R1");
        drive(16'h0000, 1'b0, 1'b1, "R1");
        drive(16'h8000, 1'b1, 1'b0, "R1");
        // R2 write to another address is ignored
        sfr_write(8'hC5, 8'h04, 1'b1);
        drive(16'h0100, 1'b0, 1'b0, "R2");
        drive(16'h7000, 1'b1, 1'b0, "R2");
        // R2 write to the register: code 2, redirect on
        sfr_write(8'hC6, 8'h2C, 1'b1);
        drive(16'h0FFF, 1'b1, 1'b0, "R2");
        drive(16'h0200, 1'b0, 1'b1, "R2");
        // R3 size bit ignored outside loader, other fields load
        sfr_write(8'hC6, 8'h00, 1'b0);
        drive(16'h4000, 1'b0, 1'b1, "R3");
        drive(16'h7FFF, 1'b0, 1'b0, "R3");
        // R10 upper bit dropped
        drive(16'hABCD, 1'b0, 1'b1, "R10");
        // full sweep: R4 R5 R6 R7 R8 R9 R11 R12
        for (int big = 0; big < 2; big++) begin
            for (int code = 0; code < 16; code++) begin
                for (int red = 0; red < 2; red++) begin
                    logic [15:0] pts[8];
                    int p, r;
                    sfr_write(8'hC6, {4'(code), 1'(big), 1'(red), 2'b00}, 1'b1);
                    p = part_of(code);
                    r = big ? 32768 : 8192;
                    pts[0] = 16'h0000; pts[1] = 16'(p - 1); pts[2] = 16'(p);
                    pts[3] = 16'(r - 1); pts[4] = 16'(r);    pts[5] = 16'h7FFF;
                    pts[6] = 16'h8000;   pts[7] = 16'hFFFF;
                    for (int k = 0; k < 8; k++) begin
                        for (int pr = 0; pr < 2; pr++) begin
                            drive(pts[k], bit'(pr), bit'(k[0]), "");
                        end
                    end
                end
            end
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule